// File: doc/BRIEF.md
# DC-Balanced 28-Bit Frame Serializer

This block turns one 24-bit parallel word into a 28-bit serial frame and moves that frame out one bit at a time, most significant bit first. A bit-rate enable, asserted 28 times per word period, advances the frame. It stands in for the high-speed clock that a PLL would otherwise provide. Each frame wraps the payload with four overhead bits. A fixed high bit and a fixed low bit give the receiver one guaranteed rising and falling edge per frame. A balance flag tells the receiver whether the payload went out inverted. A parity bit lets the receiver reject damaged frames.

A signed running-disparity register counts ones minus zeros over everything already sent. It decides, per word, whether inverting the payload brings the line closer to DC neutral. Words enter through a one-deep hold register guarded by a ready signal. The held word is loaded into the shifter only when the current frame finishes. If no fresh word has arrived by then, the held word goes out again. The serial output is qualified by a valid signal. That signal is low while the output enable is low, while the block is powered down, and before the input clock has been reported stable.

Top module: `sfr_frame_serializer`

## Requirements
- R1: A frame is 28 bits, sent first to last as: clock-high bit, payload bits 23 down to 0, balance flag, parity bit, clock-low bit. Each asserted `bit_en` while the link runs advances exactly one bit. `ser_out` shows the current bit.
- R2: The first bit of every frame is 1 and the last bit is 0.
- R3: Payload disparity is twice the number of ones minus 24. The payload is sent inverted, with the balance flag set to 1, in two cases. The first is when both the running disparity and the payload disparity are nonzero and have the same sign. The second is when the payload disparity is zero and the running disparity is negative. Otherwise the payload is sent unchanged with the flag at 0.
- R4: The running disparity starts at 0 whenever the link starts. At every frame load it changes by twice the number of ones in the 28 transmitted bits minus 28. It stays within plus or minus 28.
- R5: The parity bit makes the count of ones over the transmitted payload, the balance flag and the parity bit even.
- R6: A `word_strobe` while `ready` is 1 captures `word_in` and drops `ready` on the next cycle. A strobe while `ready` is 0 is ignored and its word never appears on the line.
- R7: The held word is loaded only in the cycle of the `bit_en` that completes a frame, and `ready` returns to 1 after that load. A strobe in that same cycle is kept for the following frame. A frame that ends with no new word resends the held word.
- R8: `ser_valid` is 1 only while the link runs, `out_en` is 1 and `pwr_up` is 1. `ser_out` is 0 whenever `ser_valid` is 0. A low `out_en` does not pause frame progress.
- R9: While `clk_stable` or `pwr_up` is 0, the link is idle: no bit advances, the disparity is cleared and `ser_valid` is 0. In the first cycle with both at 1, a frame is built from the held word, and the link runs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_stable | input | 1 | Input clock reported stable |
| pwr_up | input | 1 | 1 = powered, 0 = power-down |
| out_en | input | 1 | Serial output enable |
| word_strobe | input | 1 | Offer `word_in` to the hold register |
| word_in | input | 24 | Parallel payload word |
| bit_en | input | 1 | Serial bit-rate enable |
| ready | output | 1 | Hold register can take a word |
| ser_out | output | 1 | Current serial bit |
| ser_valid | output | 1 | Serial output is being driven |

## Verification
The bench sweeps payload words with every ones count from 0 to 24, plus walking, alternating and pseudo-random words, while carrying its own running disparity. The 12-ones words and the switch between negative and positive disparity catch a wrong tie-break or sign test; such an error gives wrong flag bits and lets the disparity drift without bound. It also checks parity over the flag as well as the payload, a strobe in the very cycle a frame completes, and a strobe while the hold register is full. A design that mishandled these would drop or duplicate words on the line. Dropping `out_en` mid-frame and toggling `clk_stable` or `pwr_up` expose a design that stalls the frame or keeps a stale disparity after restart.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int OVERHEAD_BITS = 4;

  // number of set bits in a vector (payloads up to 64 bits)
  function automatic int count_ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // inversion decision from payload and running disparity
  function automatic logic want_invert(input int word_disp, input int run_disp);
    if (run_disp == 0) return 1'b0;
    if (word_disp == 0) return run_disp < 0;
    return (word_disp > 0) == (run_disp > 0);
  endfunction

endpackage

// File: rtl/sfr_balance_enc.sv
module sfr_balance_enc
  import sfr_pkg::*;
#(
  parameter int PAYLOAD_W = 24,
  parameter int DISP_W    = 8
) (
  input  logic [PAYLOAD_W-1:0]               word_in,
  input  logic signed [DISP_W-1:0]           run_disp,
  output logic [PAYLOAD_W+OVERHEAD_BITS-1:0] frame_out,
  output logic signed [DISP_W-1:0]           next_disp,
  output logic                               invert
);
  localparam int FRAME_W = PAYLOAD_W + OVERHEAD_BITS;

  logic [PAYLOAD_W-1:0] tx_word;
  logic                 parity_bit;
  int                   word_disp;
  int                   frame_disp;

  always_comb begin
    word_disp  = 2 * count_ones(64'(word_in)) - PAYLOAD_W;
    invert     = want_invert(word_disp, int'(run_disp));
    tx_word    = invert ? ~word_in : word_in;
    parity_bit = ^{tx_word, invert};
    frame_out  = {1'b1, tx_word, invert, parity_bit, 1'b0};
    frame_disp = 2 * count_ones(64'(frame_out)) - FRAME_W;
    next_disp  = run_disp + $signed(DISP_W'(frame_disp));
  end

endmodule

// File: rtl/sfr_word_hold.sv
module sfr_word_hold #(
  parameter int PAYLOAD_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic [PAYLOAD_W-1:0] data_in,
  input  logic                 take,
  output logic [PAYLOAD_W-1:0] held_word,
  output logic                 ready,
  output logic                 accept_evt
);
  logic full;

  assign accept_evt = strobe && !full;
  assign ready      = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_word <= '0;
      full      <= 1'b0;
    end else begin
      if (accept_evt) held_word <= data_in;
      if (accept_evt)  full <= 1'b1;
      else if (take)   full <= 1'b0;
    end
  end

endmodule

// File: rtl/sfr_frame_shift.sv
module sfr_frame_shift #(
  parameter int FRAME_W = 28,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_ok,
  input  logic               bit_en,
  input  logic [FRAME_W-1:0] next_frame,
  output logic               load_evt,
  output logic               frame_end,
  output logic               active,
  output logic [IDX_W-1:0]   bit_idx,
  output logic               ser_bit
);
  logic [FRAME_W-1:0] shreg;

  assign frame_end = active && bit_en && (bit_idx == IDX_W'(FRAME_W - 1));
  assign load_evt  = link_ok && (!active || frame_end);
  assign ser_bit   = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !link_ok) begin
      active  <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (load_evt) begin
      active  <= 1'b1;
      bit_idx <= '0;
      shreg   <= next_frame;
    end else if (bit_en) begin
      bit_idx <= bit_idx + 1'b1;
      shreg   <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/sfr_frame_serializer.sv
module sfr_frame_serializer
  import sfr_pkg::*;
#(
  parameter int PAYLOAD_W = 24,
  parameter int DISP_W    = 8,
  localparam int FRAME_W  = PAYLOAD_W + OVERHEAD_BITS,
  localparam int IDX_W    = $clog2(FRAME_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_stable,
  input  logic                 pwr_up,
  input  logic                 out_en,
  input  logic                 word_strobe,
  input  logic [PAYLOAD_W-1:0] word_in,
  input  logic                 bit_en,
  output logic                 ready,
  output logic                 ser_out,
  output logic                 ser_valid
);
  logic                     link_ok;
  logic                     load_evt;
  logic                     frame_end;
  logic                     link_active;
  logic                     accept_evt;
  logic                     ser_bit;
  logic                     invert;
  logic [IDX_W-1:0]         bit_idx;
  logic [PAYLOAD_W-1:0]     held_word;
  logic [FRAME_W-1:0]       next_frame;
  logic signed [DISP_W-1:0] run_disp;
  logic signed [DISP_W-1:0] next_disp;

  assign link_ok = clk_stable && pwr_up;

  sfr_word_hold #(.PAYLOAD_W(PAYLOAD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .strobe(word_strobe), .data_in(word_in),
    .take(load_evt), .held_word(held_word), .ready(ready), .accept_evt(accept_evt)
  );

  sfr_balance_enc #(.PAYLOAD_W(PAYLOAD_W), .DISP_W(DISP_W)) u_enc (
    .word_in(held_word), .run_disp(run_disp), .frame_out(next_frame),
    .next_disp(next_disp), .invert(invert)
  );

  sfr_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .bit_en(bit_en),
    .next_frame(next_frame), .load_evt(load_evt), .frame_end(frame_end),
    .active(link_active), .bit_idx(bit_idx), .ser_bit(ser_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !link_ok) run_disp <= '0;
    else if (load_evt)      run_disp <= next_disp;
  end

  assign ser_valid = link_active && link_ok && out_en;
  assign ser_out   = ser_valid && ser_bit;

endmodule

// File: rtl/sfr_frame_checker.sv
module sfr_frame_checker #(
  parameter int FRAME_W = 28,
  parameter int DISP_W  = 8,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     link_ok,
  input logic                     load,
  input logic                     ready,
  input logic                     active,
  input logic                     bit_en,
  input logic [IDX_W-1:0]         bit_idx,
  input logic                     ser_bit,
  input logic signed [DISP_W-1:0] run_disp
);

  assert_clock_high_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_bit);

  assert_clock_low_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx == IDX_W'(FRAME_W - 1)) |-> !ser_bit);

  assert_index_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(bit_idx) < FRAME_W));

  assert_index_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && link_ok && bit_en && !load) |=> (bit_idx == $past(bit_idx) + 1'b1));

  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !load) |=> !ready);

  assert_ready_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(load));

  assert_idle_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> (!active && run_disp == '0));

  assert_disp_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_disp) <= FRAME_W) && (int'(run_disp) >= -FRAME_W));

endmodule

bind sfr_frame_serializer sfr_frame_checker #(.FRAME_W(FRAME_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .load(load_evt), .ready(ready),
  .active(link_active), .bit_en(bit_en), .bit_idx(bit_idx), .ser_bit(ser_bit),
  .run_disp(run_disp)
);

// File: tb/tb_sfr_frame_serializer.sv
module tb_sfr_frame_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_stable = 1'b0;
  logic        pwr_up = 1'b1;
  logic        out_en = 1'b1;
  logic        word_strobe = 1'b0;
  logic [23:0] word_in = '0;
  logic        bit_en = 1'b0;
  logic        ready, ser_out, ser_valid;

  int checks = 0;
  int failures = 0;
  int rd_m = 0;
  logic [23:0] hold_m = '0;
  logic [27:0] cur_m = '0;

  always #2 clk = ~clk;

  sfr_frame_serializer dut (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .pwr_up(pwr_up),
    .out_en(out_en), .word_strobe(word_strobe), .word_in(word_in),
    .bit_en(bit_en), .ready(ready), .ser_out(ser_out), .ser_valid(ser_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench model of the frame for word w; advances rd_m
  task automatic make_frame(input logic [23:0] w, output logic [27:0] f);
    int ones, pd, n;
    bit inv, par;
    logic [23:0] tx;
    ones = 0;
    for (int i = 0; i < 24; i++) if (w[i]) ones++;
    pd  = ones * 2 - 24;
    inv = (pd * rd_m > 0) || (pd == 0 && rd_m < 0);
    tx  = inv ? ~w : w;
    n = inv ? 1 : 0;
    for (int i = 0; i < 24; i++) if (tx[i]) n++;
    par = n % 2;
    f = {1'b1, tx, inv, par, 1'b0};
    n = 0;
    for (int i = 0; i < 28; i++) if (f[i]) n++;
    rd_m = rd_m + 2 * n - 28;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic offer(input logic [23:0] w);
    bit was_ready;
    was_ready = ready;
    word_strobe = 1'b1; word_in = w;
    tick();
    word_strobe = 1'b0;
    if (was_ready) hold_m = w;
    check(ready === 1'b0, "R6", "ready after strobe", 64'(ready), 64'(0));
  endtask

  task automatic send_frame(input string req, input int lo_from, input int lo_to,
                            input bit strobe_last, input logic [23:0] sw);
    logic [27:0] got;
    bit gate_bad;
    gate_bad = 1'b0;
    got = '0;
    for (int i = 0; i < 28; i++) begin
      out_en = !(i >= lo_from && i <= lo_to);
      if (strobe_last && i == 27) begin word_strobe = 1'b1; word_in = sw; end
      #0.5;
      if (!out_en) begin
        if (ser_valid !== 1'b0 || ser_out !== 1'b0) gate_bad = 1'b1;
        got[27-i] = cur_m[27-i];
      end else begin
        if (ser_valid !== 1'b1) gate_bad = 1'b1;
        got[27-i] = ser_out;
      end
      bit_en = 1'b1;
      @(posedge clk); #1;
      bit_en = 1'b0; word_strobe = 1'b0;
    end
    out_en = 1'b1;
    check(got === cur_m, req, "frame bits", 64'(got), 64'(cur_m));
    check(!gate_bad, "R8", "valid gating during frame", 64'(gate_bad), 64'(0));
    make_frame(hold_m, cur_m);
    if (strobe_last) begin
      hold_m = sw;
      check(ready === 1'b0, "R7", "strobe at frame end kept", 64'(ready), 64'(0));
    end else begin
      check(ready === 1'b1, "R7", "ready after load", 64'(ready), 64'(1));
    end
  endtask

  task automatic restart_link();
    rd_m = 0;
    tick();
    make_frame(hold_m, cur_m);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] lfsr;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(ser_valid === 1'b0 && ser_out === 1'b0, "R9", "reset output idle",
          64'({ser_valid, ser_out}), 64'(0));
    check(ready === 1'b1, "R6", "reset ready", 64'(ready), 64'(1));
    // bit enables before clock is stable do nothing
    repeat (5) begin bit_en = 1'b1; tick(); end
    bit_en = 1'b0;
    check(ser_valid === 1'b0, "R9", "idle before clock stable", 64'(ser_valid), 64'(0));

    clk_stable = 1'b1;
    restart_link();
    send_frame("R1", -1, -1, 1'b0, '0);

    // every ones count, spread over positions; ignored strobe on odd counts
    for (int k = 0; k <= 24; k++) begin
      logic [47:0] dbl;
      logic [23:0] w;
      w = (k == 24) ? 24'hFFFFFF : ((24'h1 << k) - 24'h1);
      dbl = {w, w} << ((k * 5) % 24);
      w = dbl[47:24];
      offer(w);
      if (k % 2 == 1) offer(~w ^ 24'h5A5A5A);
      send_frame("R3", -1, -1, 1'b0, '0);
    end

    // walking one and alternating patterns
    for (int b = 0; b < 24; b += 3) begin
      offer(24'h1 << b);
      send_frame("R5", -1, -1, 1'b0, '0);
    end
    offer(24'hAAAAAA); send_frame("R4", -1, -1, 1'b0, '0);
    offer(24'h555555); send_frame("R4", -1, -1, 1'b0, '0);

    // pseudo-random words
    lfsr = 24'hACE1F3;
    for (int r = 0; r < 20; r++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      offer(lfsr);
      send_frame("R4", -1, -1, 1'b0, '0);
    end

    // no new word: held word resent twice
    send_frame("R7", -1, -1, 1'b0, '0);
    send_frame("R7", -1, -1, 1'b0, '0);

    // strobe in the completing cycle
    send_frame("R7", -1, -1, 1'b1, 24'h3C0FF0);
    send_frame("R7", -1, -1, 1'b0, '0);

    // output enable low mid-frame; frame keeps advancing
    offer(24'h0F0F0F);
    send_frame("R8", 5, 15, 1'b0, '0);
    send_frame("R8", 0, 27, 1'b0, '0);
    send_frame("R8", -1, -1, 1'b0, '0);

    // clock-stable drop mid-frame, restart with cleared disparity
    for (int i = 0; i < 10; i++) begin bit_en = 1'b1; tick(); end
    bit_en = 1'b0;
    clk_stable = 1'b0;
    tick();
    repeat (3) begin bit_en = 1'b1; tick(); end
    bit_en = 1'b0;
    check(ser_valid === 1'b0 && ser_out === 1'b0, "R9", "idle after clock drop",
          64'({ser_valid, ser_out}), 64'(0));
    offer(24'h000001);
    clk_stable = 1'b1;
    restart_link();
    send_frame("R9", -1, -1, 1'b0, '0);
    send_frame("R9", -1, -1, 1'b0, '0);

    // power-down mid-frame
    for (int i = 0; i < 7; i++) begin bit_en = 1'b1; tick(); end
    bit_en = 1'b0;
    pwr_up = 1'b0;
    #0.5;
    check(ser_valid === 1'b0, "R8", "valid drops at power-down", 64'(ser_valid), 64'(0));
    tick(); tick();
    check(ser_valid === 1'b0, "R9", "idle while powered down", 64'(ser_valid), 64'(0));
    pwr_up = 1'b1;
    restart_link();
    send_frame("R9", -1, -1, 1'b0, '0);
    offer(24'hFFF000);
    send_frame("R2", -1, -1, 1'b0, '0);
    send_frame("R2", -1, -1, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule